// File: doc/BRIEF.md
# Pulse-Width Single-Wire Bit PHY

This block is the slave-side physical layer of a single-wire, open-drain bus on which every symbol is told apart only by how long the wire is held low. The wire enters through a two-flop synchronizer. A saturating counter then measures each low period in clock ticks. When the wire returns high, the measured width is sorted into one of five classes: Data 0, Data 1, Start, Attention Request and Reset. A second counter tracks how long the wire has stayed high, and from it the block reports when the bus is idle.

The pad is modelled as an input plus an active-high pull-down enable. The block pulls the wire low in three cases. After reset it pulls low for a power-up Reset. When the layer above has a 1 to return, it stretches a master read slot. When the layer above asks for attention, it issues an Attention Request. The decision is always taken from the width the wire itself showed, so a longer low that overlaps a shorter one replaces it.

Every width is a parameter in clock ticks. The defaults assume a 1 MHz sampling clock, and the thresholds sit midway between the symbol windows. Byte framing, parity and register access belong to the layer above.

Top module: `sw_pulse_phy`

## Requirements
- R1: From reset, `swd_oe` is high and stays high for exactly RST_DRV_T cycles after `rst_n` rises. The resulting low is then reported once on `reset_det`.
- R2: A low of W synchronized cycles is classified when the wire returns high, and the strobe follows one cycle later. The classes are: W < D01_T gives Data 0; D01_T ≤ W < START_T gives Data 1; START_T ≤ W < ATTN_T gives Start; ATTN_T ≤ W < RESET_T gives Attention; W ≥ RESET_T gives Reset. Data 0 and Data 1 both raise `bit_vld`, with `bit_val` = 0 for Data 0 and 1 for Data 1.
- R3: `idle` is 1 only after IDLE_T consecutive synchronized high samples. Any low sample clears it on the next cycle.
- R4: A low may begin while the bus is idle and `tx_one` is 1. In that case the block drives `swd_oe` for exactly DRV1_T cycles, starting in the cycle after the synchronized fall. With `tx_one` at 0 it does not drive.
- R5: A one-cycle pulse on `attn_req` makes a request pending. If the bus is idle, the block then drives `swd_oe` for exactly ATTN_DRV_T cycles, including when a master low starts in the same cycle as the request.
- R6: A pending request also joins a low begun by another node, provided its synchronized width is still below JOIN_T. Otherwise the request waits for idle and is issued as a separate low.
- R7: Each low pulse yields exactly one class strobe, and a longer low replaces a shorter one. `abort` pulses once in a pulse when the low reaches START_T cycles, and never in a shorter pulse.
- R8: `collision` pulses together with the class strobe when this node drove part of the low and the class differs from the one it meant to send: Data 1 for a stretch, Attention for a request, Reset at power-up.
- R9: The width counter saturates, so a low of any length above RESET_T is still reported as exactly one Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all widths count its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| swd_in | input | 1 | Raw level of the wire |
| tx_one | input | 1 | Stretch the next read slot that starts from idle (reply 1) |
| attn_req | input | 1 | Pulse: make an Attention Request pending |
| swd_oe | output | 1 | Pull the wire low when 1 |
| idle | output | 1 | Bus has been high long enough to count as inactive |
| bit_vld | output | 1 | Strobe: a data bit was received |
| bit_val | output | 1 | Value of the data bit, valid with `bit_vld` |
| start_det | output | 1 | Strobe: Start received |
| attn_det | output | 1 | Strobe: Attention Request received |
| reset_det | output | 1 | Strobe: Reset received |
| abort | output | 1 | Strobe: the current low has passed the Start threshold |
| collision | output | 1 | Strobe: this node's own symbol was overridden |

## Verification
Two functions can meet on the wire in the same cycle: this node issuing an Attention Request, and a master starting a data slot. The bench provokes the meeting in three ways. It raises `attn_req` in the same cycle as the master pull-down. It raises it a few cycles into a master low, inside the join window. It raises it late in a master low, past that window. In every case it counts the class strobes and reads the drive length. A correct block shows a single Attention, no data bit and no collision in the first two cases. In the late case it shows the master symbol followed by a separate Attention.

// File: rtl/sw_pulse_phy.sv
module sw_pulse_phy #(
  parameter int IDLE_T     = 11,
  parameter int D01_T      = 26,
  parameter int START_T    = 64,
  parameter int ATTN_T     = 137,
  parameter int RESET_T    = 290,
  parameter int JOIN_T     = 9,
  parameter int DRV1_T     = 32,
  parameter int ATTN_DRV_T = 190,
  parameter int RST_DRV_T  = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic swd_in,
  input  logic tx_one,
  input  logic attn_req,
  output logic swd_oe,
  output logic idle,
  output logic bit_vld,
  output logic bit_val,
  output logic start_det,
  output logic attn_det,
  output logic reset_det,
  output logic abort,
  output logic collision
);
  localparam int LW = $clog2(RESET_T + 1);
  localparam int HW = $clog2(IDLE_T + 1);
  localparam int DM_A = (ATTN_DRV_T > DRV1_T) ? ATTN_DRV_T : DRV1_T;
  localparam int DMAX = (RST_DRV_T > DM_A) ? RST_DRV_T : DM_A;
  localparam int DW = $clog2(DMAX + 1);

  localparam logic [1:0] OWN_NONE = 2'd0;
  localparam logic [1:0] OWN_ONE  = 2'd1;
  localparam logic [1:0] OWN_ATTN = 2'd2;
  localparam logic [1:0] OWN_RST  = 2'd3;

  localparam logic [2:0] K_D0 = 3'd0, K_D1 = 3'd1, K_ST = 3'd2, K_AT = 3'd3, K_RS = 3'd4;

  logic s1, s2, swd_q;
  logic [LW-1:0] lcnt;
  logic [HW-1:0] hcnt;
  logic drv, pend;
  logic [DW-1:0] dcnt, dlen;
  logic [1:0] own;
  logic [2:0] kind, own_kind;

  wire rise     = s2 & ~swd_q;
  wire fall     = ~s2 & swd_q;
  wire was_idle = (hcnt == HW'(IDLE_T));
  wire attn_go  = pend & ~drv & (idle | (~s2 & (lcnt < LW'(JOIN_T))));
  wire one_go   = tx_one & ~drv & fall & was_idle & ~attn_go;

  assign idle   = s2 & was_idle;
  assign swd_oe = drv;

  always_comb begin
    if (lcnt < LW'(D01_T))        kind = K_D0;
    else if (lcnt < LW'(START_T)) kind = K_D1;
    else if (lcnt < LW'(ATTN_T))  kind = K_ST;
    else if (lcnt < LW'(RESET_T)) kind = K_AT;
    else                          kind = K_RS;
  end

  always_comb begin
    case (own)
      OWN_ONE:  own_kind = K_D1;
      OWN_ATTN: own_kind = K_AT;
      OWN_RST:  own_kind = K_RS;
      default:  own_kind = K_D0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      swd_q <= 1'b1;
      lcnt <= '0;
      hcnt <= '0;
    end else begin
      s1 <= swd_in;
      s2 <= s1;
      swd_q <= s2;
      lcnt <= s2 ? '0 : ((lcnt == LW'(RESET_T)) ? lcnt : lcnt + LW'(1));
      hcnt <= !s2 ? '0 : (was_idle ? hcnt : hcnt + HW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv  <= 1'b1;
      dcnt <= '0;
      dlen <= DW'(RST_DRV_T);
      own  <= OWN_RST;
      pend <= 1'b0;
    end else begin
      pend <= attn_go ? 1'b0 : (pend | attn_req);
      if (attn_go) begin
        drv  <= 1'b1;
        dcnt <= '0;
        dlen <= DW'(ATTN_DRV_T);
        own  <= OWN_ATTN;
      end else if (one_go) begin
        drv  <= 1'b1;
        dcnt <= '0;
        dlen <= DW'(DRV1_T);
        own  <= OWN_ONE;
      end else begin
        if (drv) begin
          if (dcnt == dlen - DW'(1)) drv <= 1'b0;
          else dcnt <= dcnt + DW'(1);
        end
        if (rise) own <= OWN_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_vld   <= 1'b0;
      bit_val   <= 1'b0;
      start_det <= 1'b0;
      attn_det  <= 1'b0;
      reset_det <= 1'b0;
      abort     <= 1'b0;
      collision <= 1'b0;
    end else begin
      bit_vld   <= rise & (kind == K_D0 || kind == K_D1);
      bit_val   <= (kind == K_D1);
      start_det <= rise & (kind == K_ST);
      attn_det  <= rise & (kind == K_AT);
      reset_det <= rise & (kind == K_RS);
      abort     <= ~s2 & (lcnt == LW'(START_T - 1));
      collision <= rise & (own != OWN_NONE) & (kind != own_kind);
    end
  end

  p_one_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_vld, start_det, attn_det, reset_det}));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lcnt <= LW'(RESET_T));

  p_low_kills_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s2 |=> !idle);

  p_drive_requested_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swd_oe) |-> $past(pend | tx_one));

  p_collision_with_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> (bit_vld | start_det | attn_det | reset_det));

endmodule

// File: tb/sw_pulse_phy_test.sv
module sw_pulse_phy_test;
  localparam int IDLE_T = 4, D01_T = 6, START_T = 12, ATTN_T = 20, RESET_T = 34;
  localparam int JOIN_T = 5, DRV1_T = 6, ATTN_DRV_T = 25, RST_DRV_T = 44;

  logic clk = 0, rst_n = 0, m_oe = 0, tx_one = 0, attn_req = 0;
  logic swd_oe, idle, bit_vld, bit_val, start_det, attn_det, reset_det, abort, collision;
  wire swd = ~(m_oe | swd_oe);

  int checks = 0, fails = 0;
  int n_ev = 0, ev_first = -1, ev_last = -1, n_abort = 0, n_coll = 0, run = 0, last_run = 0;

  always #5 clk = ~clk;

  sw_pulse_phy #(.IDLE_T(IDLE_T), .D01_T(D01_T), .START_T(START_T), .ATTN_T(ATTN_T),
    .RESET_T(RESET_T), .JOIN_T(JOIN_T), .DRV1_T(DRV1_T), .ATTN_DRV_T(ATTN_DRV_T),
    .RST_DRV_T(RST_DRV_T)) uut (
    .clk(clk), .rst_n(rst_n), .swd_in(swd), .tx_one(tx_one), .attn_req(attn_req),
    .swd_oe(swd_oe), .idle(idle), .bit_vld(bit_vld), .bit_val(bit_val),
    .start_det(start_det), .attn_det(attn_det), .reset_det(reset_det),
    .abort(abort), .collision(collision));

  always @(negedge clk) if (rst_n) begin
    if (bit_vld | start_det | attn_det | reset_det) begin
      int k;
      k = bit_vld ? (bit_val ? 1 : 0) : start_det ? 2 : attn_det ? 3 : 4;
      if (n_ev == 0) ev_first = k;
      ev_last = k;
      n_ev++;
    end
    if (abort) n_abort++;
    if (collision) n_coll++;
    if (swd_oe) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  function automatic int exp_kind(int w);
    if (w < D01_T) return 0;
    if (w < START_T) return 1;
    if (w < ATTN_T) return 2;
    if (w < RESET_T) return 3;
    return 4;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_ev = 0; ev_first = -1; ev_last = -1; n_abort = 0; n_coll = 0; run = 0; last_run = 0;
  endtask

  task automatic drive_low(int len);
    @(posedge clk); #1 m_oe = 1;
    repeat (len) @(posedge clk);
    #1 m_oe = 0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 oe in reset", swd_oe, 1);
    chk("R7 no strobe in reset", bit_vld | start_det | attn_det | reset_det, 0);
    chk("R3 idle in reset", idle, 0);
    @(posedge clk); #1 rst_n = 1; clr();
    repeat (70) @(posedge clk);
    @(negedge clk);
    chk("R1 power-up drive length", last_run, RST_DRV_T);
    chk("R1 power-up events", n_ev, 1);
    chk("R1 power-up class", ev_last, 4);
    chk("R8 power-up no collision", n_coll, 0);

    for (int w = 1; w <= RESET_T + 4; w++) begin
      clr();
      drive_low(w);
      repeat (5) @(posedge clk);
      @(negedge clk); chk("R3 not idle yet", idle, 0);
      @(posedge clk); @(negedge clk); chk("R3 idle after gap", idle, 1);
      repeat (4) @(posedge clk); @(negedge clk);
      chk("R7 one event", n_ev, 1);
      chk("R2 class", ev_last, exp_kind(w));
      chk("R7 abort count", n_abort, (w >= START_T) ? 1 : 0);
      chk("R4 no drive without tx_one", last_run + run, 0);
    end

    clr(); tx_one = 1;
    drive_low(3);
    repeat (15) @(posedge clk); @(negedge clk);
    chk("R4 stretch length", last_run, DRV1_T);
    chk("R4 stretched class", ev_last, 1);
    chk("R4 events", n_ev, 1);
    chk("R8 no collision on stretch", n_coll, 0);

    clr();
    drive_low(START_T + 2);
    repeat (15) @(posedge clk); @(negedge clk);
    tx_one = 0;
    chk("R8 collision flagged", n_coll, 1);
    chk("R7 start overrides stretch", ev_last, 2);
    chk("R7 single event", n_ev, 1);

    clr();
    @(posedge clk); #1 attn_req = 1;
    @(posedge clk); #1 attn_req = 0;
    repeat (45) @(posedge clk); @(negedge clk);
    chk("R5 attention length", last_run, ATTN_DRV_T);
    chk("R5 attention class", ev_last, 3);
    chk("R5 attention events", n_ev, 1);
    chk("R8 attention no collision", n_coll, 0);

    clr();
    @(posedge clk); #1 attn_req = 1; m_oe = 1;
    @(posedge clk); #1 attn_req = 0;
    repeat (7) @(posedge clk); #1 m_oe = 0;
    repeat (45) @(posedge clk); @(negedge clk);
    chk("R5 same-cycle events", n_ev, 1);
    chk("R5 same-cycle class", ev_last, 3);
    chk("R5 same-cycle length", last_run, ATTN_DRV_T);
    chk("R8 same-cycle no collision", n_coll, 0);

    clr();
    @(posedge clk); #1 m_oe = 1;
    repeat (3) @(posedge clk); #1 attn_req = 1;
    @(posedge clk); #1 attn_req = 0;
    repeat (6) @(posedge clk); #1 m_oe = 0;
    repeat (45) @(posedge clk); @(negedge clk);
    chk("R6 join events", n_ev, 1);
    chk("R6 join class", ev_last, 3);
    chk("R6 join length", last_run, ATTN_DRV_T);

    clr();
    @(posedge clk); #1 m_oe = 1;
    repeat (9) @(posedge clk); #1 attn_req = 1;
    @(posedge clk); #1 attn_req = 0;
    repeat (6) @(posedge clk); #1 m_oe = 0;
    repeat (60) @(posedge clk); @(negedge clk);
    chk("R6 late events", n_ev, 2);
    chk("R6 late first class", ev_first, 2);
    chk("R6 late second class", ev_last, 3);
    chk("R6 late length", last_run, ATTN_DRV_T);

    clr();
    drive_low(100);
    repeat (15) @(posedge clk); @(negedge clk);
    chk("R9 long low events", n_ev, 1);
    chk("R9 long low class", ev_last, 4);
    chk("R9 long low abort", n_abort, 1);

    report();
  end
endmodule